// File: doc/BRIEF.md
# Bipolar Pseudorandom Noise Source

This block produces a stream of two-level noise samples for a sampled-signal datapath. A 32-bit maximal-style shift register advances by one step on every sample-rate strobe. The feedback bit of that step, taken from the register before it shifts, selects one of two programmable amplitude words. The chosen word appears on a signed sample output together with a one-cycle valid pulse. The strobe can come from any sample-rate event, such as a converter ready flag or a periodic timer tick. One strobe yields exactly one sample.

Software or a sequencer can reseed the register at any time. It can also rewrite the positive and negative amplitude words to scale the noise. After reset the register holds a fixed default seed and the amplitudes are plus and minus 1024. The noise sequence is therefore repeatable from reset.

Top module: `noise_source`

## Requirements
- R1: While reset is held and in the first cycle after its release, `smp_vld` is 0 and `smp_out` is 0. The register holds the default seed 0x7E521603, and the amplitude words hold +1024 (0x00000400) and -1024 (0xFFFFFC00).
- R2: On each accepted strobe, the feedback bit is the XOR of register bits 31, 30, 28 and 17 (bit 0 = LSB). The register shifts left by one, and the feedback bit enters bit 0.
- R3: A feedback bit of 1 outputs the positive amplitude word, and a feedback bit of 0 outputs the negative amplitude word.
- R4: The feedback bit that selects a sample comes from the register contents held before that strobe's shift.
- R5: When `lvl_wr` is 1, `lvl_pos` and `lvl_neg` replace the amplitude words at the next clock edge. Samples from strobes in later cycles use the new words, for example ±4096.
- R6: A strobe in the same cycle as `lvl_wr` uses the amplitude words held before that write.
- R7: `smp_vld` is 1 for exactly one clock, in the cycle after each accepted strobe. Without a strobe, `smp_vld` stays 0 and the register does not advance.
- R8: When `seed_ld` is 1, `seed_val` replaces the register at the next edge. The next sample is derived from that seed.
- R9: A `seed_val` of zero loads the default seed 0x7E521603 instead, so the register never holds all zeros.
- R10: When `seed_ld` and `smp_stb` are both 1 in one cycle, the load wins. No sample is produced, and the strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | Sample-rate strobe, one sample per high cycle |
| seed_ld | input | 1 | Seed load request |
| seed_val | input | 32 | Seed value (zero means default seed) |
| lvl_wr | input | 1 | Amplitude word write |
| lvl_pos | input | SAMPLE_W | New positive amplitude word |
| lvl_neg | input | SAMPLE_W | New negative amplitude word |
| smp_out | output | SAMPLE_W | Signed noise sample |
| smp_vld | output | 1 | Sample valid pulse |

## Verification
A wrong tap, a wrong shift direction or a pre-shift/post-shift mix-up shows at the ports within a few samples. In that case the sign pattern of `smp_out` departs from an independent sequence model. A single wrong bit usually shows within the first ten strobes. A register that advances without a strobe, or a lost seed, shifts the whole sign pattern from the next sample onward. A level applied a cycle early or late shows on the first sample taken in the write cycle. Priority and valid-timing faults show on the valid pulse in the very cycle after the stimulus.

// File: rtl/noise_pkg.sv
// Package: constants and helper for the bipolar noise source.
// Assumes a 32-bit register with fixed tap positions; only widths of the
// amplitude path are parameters of the top module.
package noise_pkg;

    localparam int unsigned STATE_W  = 32;
    localparam int unsigned TAP_A    = 31;
    localparam int unsigned TAP_B    = 30;
    localparam int unsigned TAP_C    = 28;
    localparam int unsigned TAP_D    = 17;
    localparam logic [STATE_W-1:0] SEED_DEFAULT = 32'h7E52_1603;

    typedef logic [STATE_W-1:0] state_t;

    // Feedback bit of a given register value.
    function automatic logic feedback_of(input state_t s);
        return s[TAP_A] ^ s[TAP_B] ^ s[TAP_C] ^ s[TAP_D];
    endfunction

endpackage

// File: rtl/noise_lfsr.sv
// Shift register core: holds the state, reseeds on request, advances one
// step per accepted strobe and reports the pre-shift feedback bit.
// Assumes load has priority over the advance request.
module noise_lfsr
    import noise_pkg::*;
#(
    parameter logic [31:0] DEF_SEED = SEED_DEFAULT
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   advance,
    input  logic   load,
    input  state_t load_val,
    output logic   fb,
    output state_t state
);

    state_t state_q;
    state_t next_load;

    // Replace an all-zero seed so the register cannot lock up.
    always_comb begin
        next_load = (load_val == '0) ? state_t'(DEF_SEED) : load_val;
    end

    // Feedback bit from the current (pre-shift) contents.
    always_comb begin
        fb = feedback_of(state_q);
    end

    // State register: reset to seed, load wins, else shift on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= state_t'(DEF_SEED);
        end else if (load) begin
            state_q <= next_load;
        end else if (advance) begin
            state_q <= {state_q[STATE_W-2:0], fb};
        end
    end

    assign state = state_q;

endmodule

// File: rtl/noise_levels.sv
// Amplitude word store: two signed words written together, reset to the
// default symmetric levels. A write is visible from the following cycle.
module noise_levels #(
    parameter int unsigned SAMPLE_W = 32,
    parameter int          POS_DEF  = 1024,
    parameter int          NEG_DEF  = -1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [SAMPLE_W-1:0] pos_in,
    input  logic [SAMPLE_W-1:0] neg_in,
    output logic [SAMPLE_W-1:0] pos_q,
    output logic [SAMPLE_W-1:0] neg_q
);

    localparam logic [SAMPLE_W-1:0] POS_RST = SAMPLE_W'(POS_DEF);
    localparam logic [SAMPLE_W-1:0] NEG_RST = SAMPLE_W'(NEG_DEF);

    // Hold the two amplitude words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= POS_RST;
            neg_q <= NEG_RST;
        end else if (wr) begin
            pos_q <= pos_in;
            neg_q <= neg_in;
        end
    end

endmodule

// File: rtl/noise_mapper.sv
// Output stage: turns the feedback bit of an accepted strobe into a
// registered signed sample and a one-cycle valid pulse.
module noise_mapper #(
    parameter int unsigned SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic                fb,
    input  logic [SAMPLE_W-1:0] pos_lvl,
    input  logic [SAMPLE_W-1:0] neg_lvl,
    output logic [SAMPLE_W-1:0] sample,
    output logic                valid
);

    logic [SAMPLE_W-1:0] pick;

    // Select the level for the current feedback bit.
    always_comb begin
        pick = fb ? pos_lvl : neg_lvl;
    end

    // Register the sample and raise valid for one cycle per accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= take;
            if (take) begin
                sample <= pick;
            end
        end
    end

endmodule

// File: rtl/noise_source.sv
// Top: bipolar pseudorandom noise source. One strobe gives one sample of
// either the positive or negative amplitude word, chosen by the shift
// register's feedback bit. A seed load in the same cycle drops the strobe.
module noise_source
    import noise_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 32,
    parameter int          POS_DEF  = 1024,
    parameter int          NEG_DEF  = -1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_stb,
    input  logic                seed_ld,
    input  logic [31:0]         seed_val,
    input  logic                lvl_wr,
    input  logic [SAMPLE_W-1:0] lvl_pos,
    input  logic [SAMPLE_W-1:0] lvl_neg,
    output logic [SAMPLE_W-1:0] smp_out,
    output logic                smp_vld
);

    logic                take;
    logic                fb;
    state_t              state;
    logic [SAMPLE_W-1:0] pos_q;
    logic [SAMPLE_W-1:0] neg_q;

    // Accept a strobe only when no seed load competes with it.
    always_comb begin
        take = smp_stb && !seed_ld;
    end

    noise_lfsr #(
        .DEF_SEED (SEED_DEFAULT)
    ) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (take),
        .load     (seed_ld),
        .load_val (seed_val),
        .fb       (fb),
        .state    (state)
    );

    noise_levels #(
        .SAMPLE_W (SAMPLE_W),
        .POS_DEF  (POS_DEF),
        .NEG_DEF  (NEG_DEF)
    ) u_levels (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (lvl_wr),
        .pos_in (lvl_pos),
        .neg_in (lvl_neg),
        .pos_q  (pos_q),
        .neg_q  (neg_q)
    );

    noise_mapper #(
        .SAMPLE_W (SAMPLE_W)
    ) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .fb      (fb),
        .pos_lvl (pos_q),
        .neg_lvl (neg_q),
        .sample  (smp_out),
        .valid   (smp_vld)
    );

endmodule

// File: rtl/noise_source_chk.sv
// Checker for noise_source, bound to every instance of the top module.
module noise_source_chk #(
    parameter int unsigned SAMPLE_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_stb,
    input logic                seed_ld,
    input logic [31:0]         seed_val,
    input logic [SAMPLE_W-1:0] smp_out,
    input logic                smp_vld,
    input logic [31:0]         state,
    input logic [SAMPLE_W-1:0] pos_q,
    input logic [SAMPLE_W-1:0] neg_q
);

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !seed_ld) |=> smp_vld); // R7

    AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |-> $past(smp_stb && !seed_ld)); // R7

    AST_LOAD_DROPS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        seed_ld |=> !smp_vld); // R10

    AST_SAMPLE_IS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |-> (smp_out == $past(pos_q) || smp_out == $past(neg_q))); // R3

    AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !seed_ld) |=> state[31:1] == $past(state[30:0])); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_stb && !seed_ld) |=> $stable(state)); // R7

    AST_SEED_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_ld && seed_val != 32'h0) |=> state == $past(seed_val)); // R8

    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state != 32'h0); // R9

endmodule

bind noise_source noise_source_chk #(
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_stb  (smp_stb),
    .seed_ld  (seed_ld),
    .seed_val (seed_val),
    .smp_out  (smp_out),
    .smp_vld  (smp_vld),
    .state    (state),
    .pos_q    (pos_q),
    .neg_q    (neg_q)
);

// File: tb/tb_noise_source.sv
// Directed bench for noise_source with an independent sequence model.
module tb_noise_source;

    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          smp_stb;
    logic          seed_ld;
    logic [31:0]   seed_val;
    logic          lvl_wr;
    logic [W-1:0]  lvl_pos;
    logic [W-1:0]  lvl_neg;
    logic [W-1:0]  smp_out;
    logic          smp_vld;

    int total = 0;
    int bad   = 0;

    logic [31:0]  m_reg;
    logic [W-1:0] m_pos;
    logic [W-1:0] m_neg;

    always #5 clk = ~clk;

    noise_source #(.SAMPLE_W(W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_stb  (smp_stb),
        .seed_ld  (seed_ld),
        .seed_val (seed_val),
        .lvl_wr   (lvl_wr),
        .lvl_pos  (lvl_pos),
        .lvl_neg  (lvl_neg),
        .smp_out  (smp_out),
        .smp_vld  (smp_vld)
    );

    function automatic logic m_fb(input logic [31:0] s);
        return s[31] ^ s[30] ^ s[28] ^ s[17];
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One strobe; model advances; sample checked one cycle later.
    task automatic strobe_and_check(input string req);
        logic [W-1:0] e;
        @(negedge clk);
        smp_stb = 1'b1;
        e = m_fb(m_reg) ? m_pos : m_neg;
        m_reg = {m_reg[30:0], m_fb(m_reg)};
        @(negedge clk);
        smp_stb = 1'b0;
        check({req, " valid"}, 64'(smp_vld), 64'd1);
        check({req, " sample"}, 64'(smp_out), 64'(e));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; smp_stb = 1'b0; seed_ld = 1'b0; seed_val = '0;
        lvl_wr = 1'b0; lvl_pos = '0; lvl_neg = '0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", 64'(smp_vld), 64'd0);
        check("R1 sample in reset", 64'(smp_out), 64'd0);
        rst_n = 1'b1;
        m_reg = 32'h7E52_1603; m_pos = 32'h0000_0400; m_neg = 32'hFFFF_FC00;
        @(negedge clk);
        check("R1 valid after reset", 64'(smp_vld), 64'd0);
        check("R1 sample after reset", 64'(smp_out), 64'd0);
        // first sample of default seed: taps give 1, so +1024 (R1 R4)
        strobe_and_check("R1 R4 first");
        check("R1 first is +1024", 64'(smp_out), 64'h400);
    endtask

    task automatic t_sequence();
        for (int i = 0; i < 40; i++) strobe_and_check("R2 R3 R4 sequence");
        // back-to-back strobes: valid every cycle
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            logic [W-1:0] e;
            smp_stb = 1'b1;
            e = m_fb(m_reg) ? m_pos : m_neg;
            m_reg = {m_reg[30:0], m_fb(m_reg)};
            @(negedge clk);
            check("R7 back-to-back valid", 64'(smp_vld), 64'd1);
            check("R2 back-to-back sample", 64'(smp_out), 64'(e));
        end
        smp_stb = 1'b0;
        @(negedge clk);
        check("R7 valid falls", 64'(smp_vld), 64'd0);
    endtask

    task automatic t_idle();
        repeat (10) begin
            @(negedge clk);
            check("R7 idle no valid", 64'(smp_vld), 64'd0);
        end
        strobe_and_check("R7 no advance while idle");
        @(negedge clk);
        check("R7 single pulse", 64'(smp_vld), 64'd0);
    endtask

    task automatic t_levels();
        @(negedge clk);
        lvl_wr = 1'b1; lvl_pos = 32'd4096; lvl_neg = -32'sd4096;
        @(negedge clk);
        lvl_wr = 1'b0;
        m_pos = 32'd4096; m_neg = -32'sd4096;
        for (int i = 0; i < 12; i++) strobe_and_check("R5 programmed levels");
        // same-cycle write and strobe: old words used
        @(negedge clk);
        lvl_wr = 1'b1; lvl_pos = 32'd7; lvl_neg = -32'sd7;
        smp_stb = 1'b1;
        begin
            logic [W-1:0] e;
            e = m_fb(m_reg) ? m_pos : m_neg;
            m_reg = {m_reg[30:0], m_fb(m_reg)};
            @(negedge clk);
            smp_stb = 1'b0; lvl_wr = 1'b0;
            check("R6 same-cycle write", 64'(smp_out), 64'(e));
        end
        m_pos = 32'd7; m_neg = -32'sd7;
        for (int i = 0; i < 6; i++) strobe_and_check("R6 new words after");
    endtask

    task automatic t_seed();
        @(negedge clk);
        seed_ld = 1'b1; seed_val = 32'h8000_0001;
        @(negedge clk);
        seed_ld = 1'b0;
        check("R8 no valid on load", 64'(smp_vld), 64'd0);
        m_reg = 32'h8000_0001;
        // bit31=1 only tap set: fb=1 -> positive word
        strobe_and_check("R8 seeded");
        check("R8 seeded first positive", 64'(smp_out), 64'd7);
        for (int i = 0; i < 10; i++) strobe_and_check("R8 seeded sequence");
    endtask

    task automatic t_zero_seed();
        @(negedge clk);
        seed_ld = 1'b1; seed_val = 32'h0;
        @(negedge clk);
        seed_ld = 1'b0;
        m_reg = 32'h7E52_1603;
        for (int i = 0; i < 10; i++) strobe_and_check("R9 zero seed -> default");
    endtask

    task automatic t_collision();
        @(negedge clk);
        seed_ld = 1'b1; seed_val = 32'h1234_5678; smp_stb = 1'b1;
        @(negedge clk);
        seed_ld = 1'b0; smp_stb = 1'b0;
        check("R10 strobe dropped", 64'(smp_vld), 64'd0);
        m_reg = 32'h1234_5678;
        for (int i = 0; i < 10; i++) strobe_and_check("R10 load won");
    endtask

    initial begin
        t_reset();
        t_sequence();
        t_idle();
        t_levels();
        t_seed();
        t_zero_seed();
        t_collision();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule